// File: doc/BRIEF.md
# Reset Cause Recorder and Generator

This block sits in the always-on part of a chip and turns raw restart requests into five separate, active-high reset lines. The lines cover different domains: power-on, CPU-only, debug access port, always-on peripherals and core peripherals. Each source drives only the lines its restart scope needs. A deep-sleep wake therefore leaves the always-on peripherals configured. A software reset leaves the debug setup intact. Every line rises as soon as a mapped source is seen, without waiting for a clock edge. It falls on a clock edge only after a synchroniser and a stretch counter have both run out.

Alongside the reset lines, the block keeps a cause register that records what started the most recent restart. It also keeps a lockup flag that notes when the CPU halted on an unrecoverable fault. A lockup is recorded but causes no reset. Software reads both values through a one-bit-select read port. The cause register is cleared, and reloaded, only by an always-on supply failure.

Top module: `rcg_reset_ctrl`

## Requirements
- R1: While `src_aon_fail` is high, all five reset outputs are high, `cause` reads 7'h01 and `lockup_flag` reads 0.
- R2: `cause` bit positions are fixed: bit0 always-on supply, bit1 core supply, bit2 pin, bit3 watchdog, bit4 software, bit5 deep-sleep wake, bit6 option-byte failure. Exactly one of bits 5..0 is set at all times.
- R3: A restart starts on a clock edge where at least one of core supply, pin, watchdog, software or wake is active after a sampled cycle with none of them active. The highest-priority active source is then recorded. Priority, from highest: core supply, pin, watchdog, software, wake. Sources that appear while a restart is already under way are not recorded.
- R4: `src_opt_fail` sets bit6 and leaves bits 5..0 as they were. If it is active when a restart starts, bit6 is set together with the new cause bit. A restart without it clears bit6.
- R5: Source-to-output map. Always-on supply drives all five outputs. Core supply, pin, watchdog and option-byte failure drive `rst_por`, `rst_sys`, `rst_dap` and `rst_core_per`. Software drives `rst_sys` and `rst_core_per` only.
- R6: Each output goes high asynchronously while any mapped source is active. After the last mapped source is released, it falls on the 18th rising clock edge (SYNC_STAGES + HOLD_CYCLES = 2 + 16).
- R7: `cpu_lockup` sets `lockup_flag` on the next clock edge and asserts no reset output.
- R8: `lockup_flag` is cleared on every clock edge at which `rst_sys` is high.
- R9: With `rd_sel` = 0, `rd_data` = {1'b0, cause}. With `rd_sel` = 1, `rd_data` = {7'b0, lockup_flag}.
- R10: A deep-sleep wake drives `rst_por`, `rst_sys` and `rst_core_per`. It never drives `rst_aon_per` or `rst_dap`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on free-running clock |
| src_aon_fail | input | 1 | Always-on supply failure request |
| src_core_fail | input | 1 | Core/memory supply failure request |
| src_pin | input | 1 | External reset pin request (active high) |
| src_wdog | input | 1 | Watchdog expiry request |
| src_sw | input | 1 | Software reset request from the CPU |
| src_wake | input | 1 | Deep-sleep wake request |
| src_opt_fail | input | 1 | Option-byte check failure request |
| cpu_lockup | input | 1 | CPU halted on unrecoverable fault |
| rd_sel | input | 1 | Read select: 0 cause, 1 lockup flag |
| rst_por | output | 1 | Power-on reset: CPU and all debug logic |
| rst_sys | output | 1 | System reset: CPU only |
| rst_dap | output | 1 | Debug access port reset |
| rst_aon_per | output | 1 | Always-on peripheral reset |
| rst_core_per | output | 1 | Core-domain peripheral reset |
| cause | output | 7 | Recorded restart cause |
| lockup_flag | output | 1 | Lockup status flag |
| rd_data | output | 8 | Read port data |

## Verification
The assertions check the following on every cycle:
- bits 5..0 of the cause register stay one-hot;
- a running restart never overwrites the recorded cause;
- an option-byte failure alone only adds bit6;
- no output ever falls before the hold window has elapsed;
- no reset rises without a source;
- the always-on peripheral reset rises only on an always-on supply failure;
- the system reset clears the lockup flag.

Only the bench scenarios can show the rest:
- the exact source-to-output map for each source;
- the priority choice among simultaneous sources;
- the exact 18th-edge release;
- the read-port contents after a lockup followed by a software reset.

// File: rtl/rcg_pkg.sv
package rcg_pkg;

   localparam int NUM_SRC = 7;
   localparam int NUM_RST = 5;
   localparam int NUM_PRI = 5;

   // source indices
   localparam int S_AON  = 0;
   localparam int S_CORE = 1;
   localparam int S_PIN  = 2;
   localparam int S_WDOG = 3;
   localparam int S_SW   = 4;
   localparam int S_WAKE = 5;
   localparam int S_OPT  = 6;

   // output indices: por, sys, dap, aon periph, core periph
   // mask bit i = source index i drives this output
   localparam logic [NUM_SRC-1:0] RST_MAP [NUM_RST] = '{
      7'b1101111,
      7'b1111111,
      7'b1001111,
      7'b0000001,
      7'b1111111
   };

   function automatic logic [NUM_PRI-1:0] pick_first(input logic [NUM_PRI-1:0] v);
      return v & (~v + NUM_PRI'(1));
   endfunction

endpackage

// File: rtl/rcg_stretch.sv
module rcg_stretch #(
   parameter int SYNC_STAGES = 2,
   parameter int HOLD_CYCLES = 16
) (
   input  logic clk,
   input  logic arst,
   output logic rst_out
);
   localparam int CW = $clog2(HOLD_CYCLES + 1);
   localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

   logic          ready;
   logic [CW-1:0] cnt_q;
   logic          out_q;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign ready = 1'b1;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sync_q;
         always_ff @(posedge clk or posedge arst) begin
            if (arst) sync_q <= '0;
            else      sync_q <= {sync_q[SYNC_STAGES-1:0], 1'b1} >> 0;
         end
         assign ready = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or posedge arst) begin
      if (arst) begin
         cnt_q <= '0;
         out_q <= 1'b1;
      end else if (ready && out_q) begin
         if (cnt_q == LAST) out_q <= 1'b0;
         else               cnt_q <= cnt_q + CW'(1);
      end
   end

   assign rst_out = out_q;

   // independent quiet-cycle counter for the hold check
   localparam int QW = $clog2(HOLD_CYCLES + SYNC_STAGES + 2);
   logic [QW-1:0] quiet_q;
   always_ff @(posedge clk or posedge arst) begin
      if (arst)                   quiet_q <= '0;
      else if (quiet_q != '1)     quiet_q <= quiet_q + QW'(1);
   end

   // R6
   hold_window_chk: assert property (@(posedge clk) disable iff (arst)
      $fell(rst_out) |-> (quiet_q >= QW'(HOLD_CYCLES)));

endmodule

// File: rtl/rcg_cause_rec.sv
module rcg_cause_rec
   import rcg_pkg::*;
(
   input  logic               clk,
   input  logic               aon_fail,
   input  logic [NUM_PRI-1:0] pri_src,
   input  logic               opt_fail,
   output logic [NUM_SRC-1:0] cause_q
);
   logic any_pri;
   logic busy_q;
   logic start;

   assign any_pri = |pri_src;
   assign start   = any_pri && !busy_q;

   always_ff @(posedge clk or posedge aon_fail) begin
      if (aon_fail) begin
         cause_q <= NUM_SRC'(1);
         busy_q  <= 1'b1;
      end else begin
         busy_q <= any_pri;
         if (start)         cause_q <= {opt_fail, pick_first(pri_src), 1'b0};
         else if (opt_fail) cause_q[S_OPT] <= 1'b1;
      end
   end

   // R2
   cause_onehot_chk: assert property (@(posedge clk) disable iff (aon_fail)
      $onehot(cause_q[NUM_SRC-2:0]));

   // R3
   no_overwrite_chk: assert property (@(posedge clk) disable iff (aon_fail)
      (any_pri && $past(any_pri)) |=> $stable(cause_q[NUM_SRC-2:0]));

   // R4
   opt_keeps_chk: assert property (@(posedge clk) disable iff (aon_fail)
      (opt_fail && !any_pri) |=> (cause_q[S_OPT] && $stable(cause_q[NUM_SRC-2:0])));

endmodule

// File: rtl/rcg_reset_ctrl.sv
module rcg_reset_ctrl
   import rcg_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int HOLD_CYCLES = 16
) (
   input  logic       clk,
   input  logic       src_aon_fail,
   input  logic       src_core_fail,
   input  logic       src_pin,
   input  logic       src_wdog,
   input  logic       src_sw,
   input  logic       src_wake,
   input  logic       src_opt_fail,
   input  logic       cpu_lockup,
   input  logic       rd_sel,
   output logic       rst_por,
   output logic       rst_sys,
   output logic       rst_dap,
   output logic       rst_aon_per,
   output logic       rst_core_per,
   output logic [6:0] cause,
   output logic       lockup_flag,
   output logic [7:0] rd_data
);
   generate
      if (HOLD_CYCLES < 2)  begin : g_bad_hold  $error("HOLD_CYCLES must be at least 2");  end
      if (SYNC_STAGES < 0)  begin : g_bad_sync  $error("SYNC_STAGES must not be negative"); end
   endgenerate

   logic [NUM_SRC-1:0] srcs;
   logic [NUM_RST-1:0] rst_vec;
   logic [NUM_SRC-1:0] cause_q;
   logic               lock_q;

   assign srcs = {src_opt_fail, src_wake, src_sw, src_wdog, src_pin, src_core_fail, src_aon_fail};

   generate
      for (genvar g = 0; g < NUM_RST; g++) begin : g_rst
         logic req;
         assign req = |(srcs & RST_MAP[g]);
         rcg_stretch #(
            .SYNC_STAGES(SYNC_STAGES),
            .HOLD_CYCLES(HOLD_CYCLES)
         ) stretch_i (
            .clk    (clk),
            .arst   (req),
            .rst_out(rst_vec[g])
         );
      end
   endgenerate

   assign rst_por      = rst_vec[0];
   assign rst_sys      = rst_vec[1];
   assign rst_dap      = rst_vec[2];
   assign rst_aon_per  = rst_vec[3];
   assign rst_core_per = rst_vec[4];

   rcg_cause_rec cause_i (
      .clk     (clk),
      .aon_fail(src_aon_fail),
      .pri_src (srcs[S_WAKE:S_CORE]),
      .opt_fail(src_opt_fail),
      .cause_q (cause_q)
   );

   always_ff @(posedge clk or posedge src_aon_fail) begin
      if (src_aon_fail)    lock_q <= 1'b0;
      else if (rst_sys)    lock_q <= 1'b0;
      else if (cpu_lockup) lock_q <= 1'b1;
   end

   assign cause       = cause_q;
   assign lockup_flag = lock_q;
   assign rd_data     = rd_sel ? {7'b0, lock_q} : {1'b0, cause_q};

   // R7
   rise_needs_src_chk: assert property (@(posedge clk) disable iff (src_aon_fail)
      $rose(|rst_vec) |-> (|srcs));

   // R10
   aon_per_only_aon_chk: assert property (@(posedge clk)
      $rose(rst_aon_per) |-> src_aon_fail);

   // R8
   lock_clear_chk: assert property (@(posedge clk) disable iff (src_aon_fail)
      rst_sys |=> !lockup_flag);

endmodule

// File: tb/rcg_reset_ctrl_tb_top.sv
module rcg_reset_ctrl_tb_top;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic aon = 1'b0, core = 1'b0, pin = 1'b0, wdog = 1'b0, sw = 1'b0, wake = 1'b0, opt = 1'b0;
   logic lockup = 1'b0, rd_sel = 1'b0;
   logic rst_por, rst_sys, rst_dap, rst_aon_per, rst_core_per, lockup_flag;
   logic [6:0] cause;
   logic [7:0] rd_data;

   int checks = 0;
   int failures = 0;

   rcg_reset_ctrl dut_i (
      .clk(clk), .src_aon_fail(aon), .src_core_fail(core), .src_pin(pin),
      .src_wdog(wdog), .src_sw(sw), .src_wake(wake), .src_opt_fail(opt),
      .cpu_lockup(lockup), .rd_sel(rd_sel),
      .rst_por(rst_por), .rst_sys(rst_sys), .rst_dap(rst_dap),
      .rst_aon_per(rst_aon_per), .rst_core_per(rst_core_per),
      .cause(cause), .lockup_flag(lockup_flag), .rd_data(rd_data)
   );

   function automatic logic [4:0] outs();
      return {rst_core_per, rst_aon_per, rst_dap, rst_sys, rst_por};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic drive(input logic [6:0] s);
      {opt, wake, sw, wdog, pin, core, aon} = s;
   endtask

   // {sources opt..aon, expected cause, expected outputs corep,aonp,dap,sys,por}
   localparam logic [18:0] VEC [12] = '{
      {7'b0000010, 7'b0000010, 5'b10111},
      {7'b0000100, 7'b0000100, 5'b10111},
      {7'b0001000, 7'b0001000, 5'b10111},
      {7'b0010000, 7'b0010000, 5'b10010},
      {7'b0100000, 7'b0100000, 5'b10011},
      {7'b0000001, 7'b0000001, 5'b11111},
      {7'b0110100, 7'b0000100, 5'b10111},
      {7'b0011000, 7'b0001000, 5'b10111},
      {7'b1100000, 7'b1100000, 5'b10111},
      {7'b0001110, 7'b0000010, 5'b10111},
      {7'b1000000, 7'b1000010, 5'b10111},
      {7'b0010000, 7'b0010000, 5'b10010}
   };

   task automatic release_and_time(input logic [4:0] exp_outs, input string tag);
      drive(7'b0);
      repeat (17) @(negedge clk);
      chk({tag, " R6 held at edge 17"}, 32'(outs()), 32'(exp_outs));
      @(negedge clk);
      chk({tag, " R6 released at edge 18"}, 32'(outs()), 32'h0);
   endtask

   initial begin
      #5 aon = 1'b1;
      @(negedge clk);
      @(negedge clk);
      // R1 reset state
      chk("R1 outputs", 32'(outs()), 32'h1f);
      chk("R1 cause", 32'(cause), 32'h01);
      chk("R1 lockup", 32'(lockup_flag), 32'h0);
      rd_sel = 1'b0; #1;
      chk("R9 read cause", 32'(rd_data), 32'h01);
      @(negedge clk);
      release_and_time(5'b11111, "aon");

      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         drive(VEC[i][18:12]);
         #2;
         chk($sformatf("R5/R10 vec%0d outputs", i), 32'(outs()), 32'(VEC[i][4:0]));
         @(negedge clk);
         chk($sformatf("R2/R3/R4 vec%0d cause", i), 32'(cause), 32'(VEC[i][11:5]));
         chk($sformatf("R9 vec%0d read", i), 32'(rd_data), {25'b0, 7'(VEC[i][11:5])});
         repeat (2) @(negedge clk);
         release_and_time(VEC[i][4:0], $sformatf("vec%0d", i));
      end

      // R3: late arrival ignored
      @(negedge clk);
      drive(7'b0000100);
      @(negedge clk);
      drive(7'b0001100);
      @(negedge clk);
      chk("R3 late watchdog not recorded", 32'(cause), 32'h04);
      release_and_time(5'b10111, "late");

      // R7: lockup sets flag, no reset
      @(negedge clk);
      lockup = 1'b1;
      @(negedge clk);
      lockup = 1'b0;
      rd_sel = 1'b1; #1;
      chk("R7 lockup flag", 32'(lockup_flag), 32'h1);
      chk("R9 read lockup", 32'(rd_data), 32'h1);
      repeat (20) @(negedge clk);
      chk("R7 no reset on lockup", 32'(outs()), 32'h0);
      chk("R7 flag persists", 32'(lockup_flag), 32'h1);

      // R8: software reset clears lockup
      drive(7'b0010000);
      @(negedge clk);
      chk("R8 lockup cleared", 32'(rd_data), 32'h0);
      release_and_time(5'b10010, "swclr");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule